// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Shifting Line Refill

This block is a read-only, direct-mapped cache placed between a pipeline stage and a word-addressed memory port. The requester drives `req_i` with a word address. It holds both until `valid_o` is high, and in that same cycle it takes the word from `rdata_o`. The address is split into an upper tag, a middle line index and a low word offset. The indexed line's stored tag and valid flag decide whether the access hits.

On a hit the word comes back in the same cycle as the request. On a miss the block fetches the entire line that holds the requested word, one word per accepted memory beat. A loadable counter supplies the consecutive memory addresses, starting from the line-aligned base. Every word slot of the line sees the returned data at the same time. A one-hot shift register enables exactly one slot per beat and then moves on to the next slot. After the final beat the tag and valid flag are written, and the requested word is returned in the next cycle.

The requester must not change the address while a request is outstanding. The block takes no new lookup until the refill and its response cycle are complete.

Top module: `dmc_cache`

## Requirements
- R1: After reset every line is invalid and `valid_o` and `mem_req_o` are low. The first access to any line is therefore a miss.
- R2: A hit occurs when the indexed line is valid and its stored tag equals the address tag. On a hit, `valid_o` is high in the same cycle as `req_i`, `rdata_o` carries the stored word, and no memory request is made.
- R3: A miss makes exactly WORDS memory accepts. They start in the cycle after the request, at consecutive addresses beginning at the line base, which is the request address with its offset bits cleared.
- R4: While `mem_ready_i` is low, `mem_addr_o` holds and no word is written. Each cycle in which `mem_req_o` and `mem_ready_i` are both high accepts exactly one word.
- R5: `valid_o` stays low for the whole refill. It is high for one cycle, in the cycle directly after the last word is accepted. The miss latency is therefore 1 + (number of refill cycles).
- R6: After a refill, `rdata_o` is the memory word at the original word offset. Each word of the line holds its own memory word, so later hits at any offset of that line return the correct data.
- R7: The line index is the address bits just above the offset bits (offset is the lowest log2(WORDS) bits), and the tag is the remaining upper bits. Two addresses with equal index and different tags evict each other. Lines with different indexes are held at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Lookup request, held until `valid_o` |
| addr_i | input | ADDR_W | Word address of the request |
| valid_o | output | 1 | Read data valid |
| rdata_o | output | DATA_W | Read data |
| mem_req_o | output | 1 | Memory fetch request during refill |
| mem_addr_o | output | ADDR_W | Memory word address being fetched |
| mem_ready_i | input | 1 | Memory returns `mem_rdata_i` for `mem_addr_o` this cycle |
| mem_rdata_i | input | DATA_W | Memory read data |

## Verification
The bench builds the cache with 4 lines of 4 words and a 10-bit address. This leaves a 6-bit tag, so conflicting addresses are easy to pick and a short sweep fills every line. Because a line holds only four words, the first and the last word positions both appear in many refills. The bench keeps its own tag model to predict hit or miss. It uses that prediction, together with a configurable number of memory wait states, to predict the exact latency and the number of memory beats for each access.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_REFILL  = 2'd1,
    ST_RESPOND = 2'd2
  } dmc_state_e;
endpackage

// File: rtl/dmc_word_ram.sv
module dmc_word_ram #(
  parameter int LINES  = 16,
  parameter int WORDS  = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFS_W = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic [WORDS-1:0]  we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  input  logic [OFS_W-1:0]  roff_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] word_rd [WORDS];

  // one bank per word slot, shared write data, private write enable
  for (genvar w = 0; w < WORDS; w++) begin : g_bank
    logic [DATA_W-1:0] mem [LINES];
    always_ff @(posedge clk_i) begin
      if (we_i[w]) mem[widx_i] <= wdata_i;
    end
    assign word_rd[w] = mem[ridx_i];
  end

  assign rdata_o = word_rd[roff_i];
endmodule

// File: rtl/dmc_onehot_shift.sv
module dmc_onehot_shift #(
  parameter int WORDS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  output logic [WORDS-1:0] sel_o,
  output logic             last_o
);
  logic [WORDS-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_q <= '0;
    else if (load_i) sel_q <= WORDS'(1);
    else if (step_i) sel_q <= sel_q << 1;
  end

  assign sel_o  = sel_q;
  assign last_o = sel_q[WORDS-1];
endmodule

// File: rtl/dmc_addr_ctr.sv
module dmc_addr_ctr #(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= base_i;
    else if (step_i) cnt_q <= cnt_q + ADDR_W'(1);
  end

  assign addr_o = cnt_q;

  assert_base_aligned_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (addr_o[OFS_W-1:0] == '0));
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter int WORDS  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ready_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int OFS_W = $clog2(WORDS);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W - OFS_W;

  dmc_state_e state_q, state_d;

  logic [TAG_W-1:0] req_tag;
  logic [IDX_W-1:0] req_idx;
  logic [OFS_W-1:0] req_off;
  assign req_tag = addr_i[ADDR_W-1 -: TAG_W];
  assign req_idx = addr_i[OFS_W +: IDX_W];
  assign req_off = addr_i[OFS_W-1:0];

  logic [TAG_W-1:0] tag_mem [LINES];
  logic [LINES-1:0] vld_q;
  logic [TAG_W-1:0] tag_hold_q;
  logic [IDX_W-1:0] idx_hold_q;
  logic [OFS_W-1:0] off_hold_q;

  logic             hit, start_fill, beat, fill_done, last;
  logic [WORDS-1:0] sel;
  logic [IDX_W-1:0] ridx;
  logic [OFS_W-1:0] roff;

  assign hit        = vld_q[req_idx] && (tag_mem[req_idx] == req_tag);
  assign start_fill = (state_q == ST_IDLE) && req_i && !hit;
  assign beat       = (state_q == ST_REFILL) && mem_ready_i;
  assign fill_done  = beat && last;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_fill) state_d = ST_REFILL;
      ST_REFILL:  if (fill_done)  state_d = ST_RESPOND;
      ST_RESPOND: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      vld_q      <= '0;
      tag_hold_q <= '0;
      idx_hold_q <= '0;
      off_hold_q <= '0;
    end else begin
      state_q <= state_d;
      if (start_fill) begin
        tag_hold_q <= req_tag;
        idx_hold_q <= req_idx;
        off_hold_q <= req_off;
      end
      if (fill_done) vld_q[idx_hold_q] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_done) tag_mem[idx_hold_q] <= tag_hold_q;
  end

  dmc_addr_ctr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) i_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start_fill),
    .base_i ({req_tag, req_idx, {OFS_W{1'b0}}}),
    .step_i (beat),
    .addr_o (mem_addr_o)
  );

  dmc_onehot_shift #(.WORDS(WORDS)) i_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start_fill),
    .step_i (beat),
    .sel_o  (sel),
    .last_o (last)
  );

  assign ridx = (state_q == ST_IDLE) ? req_idx : idx_hold_q;
  assign roff = (state_q == ST_IDLE) ? req_off : off_hold_q;

  dmc_word_ram #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)) i_ram (
    .clk_i   (clk_i),
    .we_i    (sel & {WORDS{beat}}),
    .widx_i  (idx_hold_q),
    .wdata_i (mem_rdata_i),
    .ridx_i  (ridx),
    .roff_i  (roff),
    .rdata_o (rdata_o)
  );

  assign mem_req_o = (state_q == ST_REFILL);
  assign valid_o   = ((state_q == ST_IDLE) && req_i && hit) || (state_q == ST_RESPOND);

  assert_refill_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> $onehot(sel));
  assert_addr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ready_i && !last) |=> (mem_addr_o == $past(mem_addr_o) + ADDR_W'(1)));
  assert_addr_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)));
  assert_quiet_refill_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !valid_o);
  assert_valid_after_last_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ready_i && last) |=> (valid_o && !mem_req_o));
  assert_hit_no_fetch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_IDLE) && valid_o) |=> !mem_req_o);
endmodule

// File: tb/test_dmc_cache.sv
module test_dmc_cache;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int LINES  = 4;
  localparam int WORDS  = 4;
  localparam int OFS_W  = 2;
  localparam int IDX_W  = 2;
  localparam int TAG_W  = ADDR_W - IDX_W - OFS_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic              req;
  logic [ADDR_W-1:0] addr;
  logic              valid;
  logic [DATA_W-1:0] rdata;
  logic              mem_req;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_ready;
  logic [DATA_W-1:0] mem_rdata;

  dmc_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WORDS(WORDS)) i_dmc_cache (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr),
    .valid_o(valid), .rdata_o(rdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int                wait_n = 0;
  int                beat = 0;
  logic [ADDR_W-1:0] exp_base = '0;
  bit                in_flight = 1'b0;
  bit                done = 1'b0;
  int                t0 = 0;

  logic [DATA_W-1:0] exp_q[$];
  int                lat_q[$];
  int                beats_q[$];
  string             tag_q[$];

  logic [TAG_W-1:0] m_tag [LINES];
  bit               m_vld [LINES];

  function automatic logic [DATA_W-1:0] mem_f(input logic [ADDR_W-1:0] a);
    return 32'hC0DE0000 ^ (32'(a) * 32'h00019E37);
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // memory responder: inserts wait_n idle cycles before each beat
  initial begin
    int cnt = 0;
    mem_ready = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      mem_ready = 1'b0;
      if (mem_req) begin
        if (cnt < wait_n) begin
          cnt++;
          check(mem_addr == ADDR_W'(exp_base + ADDR_W'(beat)), "R4", "addr during wait",
                64'(mem_addr), 64'(exp_base + ADDR_W'(beat)));
        end else begin
          cnt = 0;
          check((beat < WORDS) && (mem_addr == ADDR_W'(exp_base + ADDR_W'(beat))), "R3",
                "fetch addr", 64'(mem_addr), 64'(exp_base + ADDR_W'(beat)));
          mem_ready = 1'b1;
          mem_rdata = mem_f(mem_addr);
          beat++;
        end
      end else begin
        cnt = 0;
      end
    end
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (valid && rst_n) begin
        if (!in_flight) begin
          check(1'b0, "R5", "valid without request", 64'd1, 64'd0);
        end else begin
          logic [DATA_W-1:0] e;
          int l, b;
          string t;
          e = exp_q.pop_front();
          l = lat_q.pop_front();
          b = beats_q.pop_front();
          t = tag_q.pop_front();
          check(rdata == e, t, "read data", 64'(rdata), 64'(e));
          check((cyc - t0) == l, "R5", "latency", 64'(cyc - t0), 64'(l));
          check(beat == b, (b == 0) ? "R2" : "R3", "memory beats", 64'(beat), 64'(b));
          in_flight = 1'b0;
          done = 1'b1;
        end
      end
    end
  end

  task automatic access(input logic [ADDR_W-1:0] a);
    logic [IDX_W-1:0] ix;
    logic [TAG_W-1:0] tg;
    bit miss;
    ix = a[OFS_W +: IDX_W];
    tg = a[ADDR_W-1 -: TAG_W];
    miss = !(m_vld[ix] && m_tag[ix] == tg);
    exp_q.push_back(mem_f(a));
    lat_q.push_back(miss ? 1 + WORDS * (wait_n + 1) : 0);
    beats_q.push_back(miss ? WORDS : 0);
    tag_q.push_back(miss ? "R6" : "R2");
    @(negedge clk);
    exp_base = {a[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
    beat = 0;
    done = 1'b0;
    in_flight = 1'b1;
    t0 = cyc;
    addr = a;
    req = 1'b1;
    wait (done);
    req = 1'b0;
    if (miss) begin
      m_vld[ix] = 1'b1;
      m_tag[ix] = tg;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    check(1'b0, "watchdog", "run did not finish", 64'(cyc), 64'd0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    req = 1'b0;
    addr = '0;
    for (int i = 0; i < LINES; i++) begin
      m_vld[i] = 1'b0;
      m_tag[i] = '0;
    end
    repeat (3) @(negedge clk);
    #5;
    check(valid == 1'b0, "R1", "valid in reset", 64'(valid), 64'd0);
    check(mem_req == 1'b0, "R1", "mem_req in reset", 64'(mem_req), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #5;
    check(valid == 1'b0 && mem_req == 1'b0, "R1", "idle after reset",
          64'({valid, mem_req}), 64'd0);

    // R1/R6: first access misses, last offset returned
    access(10'h013);
    // R2/R6: hits to the other words of the same line
    access(10'h010);
    access(10'h011);
    access(10'h012);
    // R7: another index coexists
    access(10'h024);
    access(10'h013);
    access(10'h027);
    // R7: same index, other tag evicts
    access(10'h113);
    access(10'h013);
    access(10'h110);
    // R4: memory wait states
    wait_n = 2;
    access(10'h038);
    access(10'h03B);
    wait_n = 1;
    access(10'h0C5);
    access(10'h0C6);
    // sweep every line, then conflict sweep, then revisit
    wait_n = 0;
    for (int i = 0; i < 16; i++) access(ADDR_W'(10'h200 + i));
    for (int i = 0; i < 16; i++) access(ADDR_W'(10'h3F0 + i));
    wait_n = 3;
    for (int i = 15; i >= 0; i--) access(ADDR_W'(10'h200 + i));

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule